// File: doc/BRIEF.md
# Quadrature Encoder to Count-Pulse Converter

This block takes the two phase signals of an incremental encoder and turns every accepted phase change into a direction-tagged count pulse. A standard up/down counter can use these pulses directly. Both phase inputs pass through a two-flop synchronizer and a stability filter. The decoder then compares the filtered pair against a stored reference and counts at single, double or quadruple resolution.

Each count is a low-going pulse whose length is a programmed number of system clock cycles. The pulse length does not depend on how fast the encoder edges arrive. While a pulse is being driven, further phase changes update the reference but produce no count, so the dither of an encoder resting on an edge is absorbed.

A build parameter selects one of two output styles. The split style drives separate up and down pulse lines. The combined style drives one pulse line plus a direction level that has settled before the pulse's rising edge.

Top module: `qpc_converter`

## Requirements
- R1: With `res_sel` = 2'b00 the block counts once per encoder cycle, only when A rises: an up count if B is low at that edge, a down count if B is high.
- R2: With `res_sel` = 2'b01 the block counts on both edges of A, which gives two counts per encoder cycle.
- R3: With `res_sel` = 2'b10 the block counts on every accepted change of A or B, which gives four counts per encoder cycle.
- R4: The phase sequence 00→10→11→01→00 (written as {A,B}, A leading) produces up counts. The reverse sequence produces down counts.
- R5: A count pulse idles high and stays low for exactly `pw_cyc` clock cycles. A `pw_cyc` of 0 gives one cycle.
- R6: A level change on A or B that lasts fewer than `FILT_CYC` clock cycles produces no count and no error.
- R7: Phase changes accepted while a count pulse is low produce no count. The reference still follows them, so the next real change counts correctly.
- R8: When A and B change in the same filtered sample, no count pulse is produced and `err` is high for exactly one cycle.
- R9: In the combined style (`SPLIT_OUT` = 0), every count appears on `cnt_n`. `dir_up` is 1 for up and 0 for down, and it stays constant while `cnt_n` is low and at its rising edge. `up_n` and `dn_n` stay high.
- R10: In the split style (`SPLIT_OUT` = 1), up counts appear on `up_n` and down counts on `dn_n`. The two are never low together, and `cnt_n` stays high.
- R11: While `rst` is high and in the first cycle after it, all pulse outputs are high, `dir_up` is 1 and `err` is 0. Reset takes the current filtered A/B pair as the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 1 | Encoder phase A, asynchronous |
| b_in | input | 1 | Encoder phase B, asynchronous |
| res_sel | input | 2 | Resolution: 00 single, 01 double, 10 quadruple |
| pw_cyc | input | PW_W | Count pulse length in clock cycles |
| up_n | output | 1 | Active-low up count pulse (split style) |
| dn_n | output | 1 | Active-low down count pulse (split style) |
| cnt_n | output | 1 | Active-low combined count pulse (combined style) |
| dir_up | output | 1 | Count direction, 1 = up |
| err | output | 1 | One-cycle flag for a simultaneous A/B change |

## Verification
A wrong reference state shows up at the ports within one filter window after the next phase change, as a count with the wrong direction, a missing count or a spurious `err`. The lockout case is the sharpest test of this: if the reference stopped following the phase changes during a pulse, the first change after the pulse would be miscounted. A wrong pulse counter shows up at the first rising edge of the pulse as a low time that differs from `pw_cyc`. A direction register that is loaded at the wrong time shows up as `dir_up` changing while `cnt_n` is low.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic [1:0] {
        RES_X1 = 2'b00,
        RES_X2 = 2'b01,
        RES_X4 = 2'b10
    } res_e;

    typedef struct packed {
        logic a;
        logic b;
    } phase_t;

    typedef struct packed {
        logic hit;   // a count is due
        logic up;    // direction of that count
        logic bad;   // both phases moved together
    } step_t;

    // Position of a phase pair on the forward Gray cycle 00,10,11,01
    function automatic logic [1:0] gray_pos(phase_t p);
        case ({p.a, p.b})
            2'b00:   return 2'd0;
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic step_t classify(phase_t prev, phase_t cur, res_e res);
        step_t      s;
        logic       fwd;
        logic       a_chg;
        logic       b_chg;
        s     = '0;
        a_chg = prev.a ^ cur.a;
        b_chg = prev.b ^ cur.b;
        fwd   = (gray_pos(cur) == gray_pos(prev) + 2'd1);
        s.up  = fwd;
        if (a_chg && b_chg) begin
            s.bad = 1'b1;
        end else begin
            case (res)
                RES_X1:  s.hit = a_chg && cur.a;
                RES_X2:  s.hit = a_chg;
                RES_X4:  s.hit = a_chg || b_chg;
                default: s.hit = 1'b0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/qpc_phase_filter.sv
module qpc_phase_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          s1_q;
    logic          s2_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        s1_q <= raw;
        s2_q <= s1_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= s2_q;
            run_q <= '0;
        end else if (s2_q == level) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT_CYC - 1)) begin
            level <= s2_q;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/qpc_pulse_gen.sv
module qpc_pulse_gen #(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            start_up,
    input  logic [PW_W-1:0] width,
    output logic            busy,
    output logic            dir_q
);
    logic [PW_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            dir_q  <= 1'b1;
            left_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy   <= 1'b1;
                dir_q  <= start_up;
                left_q <= (width == '0) ? '0 : width - 1'b1;
            end
        end else if (left_q == '0) begin
            busy <= 1'b0;
        end else begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/qpc_converter.sv
module qpc_converter
    import qpc_pkg::*;
#(
    parameter int FILT_CYC  = 4,
    parameter int PW_W      = 8,
    parameter bit SPLIT_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            a_in,
    input  logic            b_in,
    input  logic [1:0]      res_sel,
    input  logic [PW_W-1:0] pw_cyc,
    output logic            up_n,
    output logic            dn_n,
    output logic            cnt_n,
    output logic            dir_up,
    output logic            err
);
    localparam int NPH = 2;

    logic [NPH-1:0] raw_vec;
    logic [NPH-1:0] filt_vec;
    phase_t         filt;
    phase_t         ref_q;
    step_t          st;
    logic           busy;
    logic           dir_q;
    logic           start;

    assign raw_vec = {a_in, b_in};

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        qpc_phase_filter #(.FILT_CYC(FILT_CYC)) flt_i (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_vec[i]),
            .level(filt_vec[i])
        );
    end

    assign filt  = phase_t'(filt_vec);
    assign st    = classify(ref_q, filt, res_e'(res_sel));
    assign start = st.hit && !busy;

    // Reference follows the filtered pair even during lockout
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= filt;
            err   <= 1'b0;
        end else begin
            ref_q <= filt;
            err   <= st.bad && !busy;
        end
    end

    qpc_pulse_gen #(.PW_W(PW_W)) pg_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .start_up(st.up),
        .width   (pw_cyc),
        .busy    (busy),
        .dir_q   (dir_q)
    );

    if (SPLIT_OUT) begin : g_split
        assign up_n  = !(busy && dir_q);
        assign dn_n  = !(busy && !dir_q);
        assign cnt_n = 1'b1;
    end else begin : g_comb
        assign up_n  = 1'b1;
        assign dn_n  = 1'b1;
        assign cnt_n = !busy;
    end
    assign dir_up = dir_q;

endmodule

// File: rtl/qpc_converter_chk.sv
module qpc_converter_chk #(
    parameter bit SPLIT_OUT = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic up_n,
    input logic dn_n,
    input logic cnt_n,
    input logic dir_up,
    input logic err
);
    // R10
    a_r10_no_double_low: assert property (@(posedge clk) disable iff (rst)
        !(!up_n && !dn_n));

    a_r10_cnt_idle: assert property (@(posedge clk) disable iff (rst)
        SPLIT_OUT |-> cnt_n);

    // R9
    a_r9_split_idle: assert property (@(posedge clk) disable iff (rst)
        !SPLIT_OUT |-> (up_n && dn_n));

    a_r9_dir_held: assert property (@(posedge clk) disable iff (rst)
        (!SPLIT_OUT && $past(!cnt_n) && (!cnt_n || $rose(cnt_n))) |-> $stable(dir_up));

    // R8
    a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    a_r8_err_no_count: assert property (@(posedge clk) disable iff (rst)
        err |-> !($fell(up_n) || $fell(dn_n) || $fell(cnt_n)));

    // R11
    a_r11_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (up_n && dn_n && cnt_n && dir_up && !err));

endmodule

bind qpc_converter qpc_converter_chk #(.SPLIT_OUT(SPLIT_OUT)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .up_n  (up_n),
    .dn_n  (dn_n),
    .cnt_n (cnt_n),
    .dir_up(dir_up),
    .err   (err)
);

// File: tb/qpc_converter_tb_top.sv
module qpc_converter_tb_top;
    localparam int FILT = 4;
    localparam int PWW  = 8;
    localparam int GAP  = 24;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           a = 1'b0;
    logic           b = 1'b0;
    logic [1:0]     res = 2'b10;
    logic [PWW-1:0] pw = 8'd5;
    logic up_n, dn_n, cnt_n, dir_up, err;
    logic c_up_n, c_dn_n, c_cnt_n, c_dir_up, c_err;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    qpc_converter #(.FILT_CYC(FILT), .PW_W(PWW), .SPLIT_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .res_sel(res), .pw_cyc(pw),
        .up_n(up_n), .dn_n(dn_n), .cnt_n(cnt_n), .dir_up(dir_up), .err(err));

    qpc_converter #(.FILT_CYC(FILT), .PW_W(PWW), .SPLIT_OUT(1'b0)) dut_c (
        .clk(clk), .rst(rst), .a_in(a), .b_in(b), .res_sel(res), .pw_cyc(pw),
        .up_n(c_up_n), .dn_n(c_dn_n), .cnt_n(c_cnt_n), .dir_up(c_dir_up), .err(c_err));

    // Port monitor, sampled on the falling edge
    int n_up = 0, n_dn = 0, n_err = 0, n_cup = 0, n_cdn = 0;
    int run = 0, last_w = 0, n_split_bad = 0, n_cidle_bad = 0, n_dirmove = 0;
    logic p_up = 1'b1, p_dn = 1'b1, p_cnt = 1'b1, p_dir = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_up && !up_n) n_up++;
            if (p_dn && !dn_n) n_dn++;
            if (err) n_err++;
            if (!up_n || !dn_n) run++;
            if ((!p_up && up_n) || (!p_dn && dn_n)) begin
                last_w = run;
                run = 0;
            end
            if (!p_cnt && c_cnt_n) begin
                if (c_dir_up) n_cup++; else n_cdn++;
            end
            if (!p_cnt && c_dir_up != p_dir) n_dirmove++;
            if (!cnt_n) n_split_bad++;
            if (!c_up_n || !c_dn_n) n_cidle_bad++;
        end
        p_up = up_n; p_dn = dn_n; p_cnt = c_cnt_n; p_dir = c_dir_up;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic na, input logic nb);
        @(negedge clk);
        a = na; b = nb;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (6) @(negedge clk);
        chk(up_n && dn_n && cnt_n && c_cnt_n && dir_up && c_dir_up && !err, "R11 reset outputs",
            {up_n, dn_n, cnt_n, dir_up, err}, 5'b11110);
        rst = 1'b0;
        @(negedge clk);
        chk(up_n && dn_n && c_cnt_n && dir_up && !err, "R11 after release",
            {up_n, dn_n, c_cnt_n, dir_up, err}, 5'b11110);
    endtask

    task automatic t_mode(input logic [1:0] m, input int per, input string req);
        int u0, d0, cu0, cd0;
        res = m;
        u0 = n_up; d0 = n_dn; cu0 = n_cup; cd0 = n_cdn;
        step(1, 0); step(1, 1); step(0, 1); step(0, 0);
        chk(n_up - u0 == per && n_dn == d0, {req, " R4 forward up counts"}, n_up - u0, per);
        chk(n_cup - cu0 == per, {req, " R9 combined up"}, n_cup - cu0, per);
        d0 = n_dn; u0 = n_up;
        step(0, 1); step(1, 1); step(1, 0); step(0, 0);
        chk(n_dn - d0 == per && n_up == u0, {req, " R4 reverse down counts"}, n_dn - d0, per);
        chk(n_cdn - cd0 == per, {req, " R9 combined down"}, n_cdn - cd0, per);
    endtask

    task automatic t_width(input int w, input int exp);
        pw = PWW'(w);
        res = 2'b10;
        step(1, 0);
        chk(last_w == exp, "R5 pulse width", last_w, exp);
        step(0, 0);
        chk(last_w == exp, "R5 pulse width down", last_w, exp);
        pw = 8'd5;
    endtask

    task automatic t_glitch();
        int u0, d0, e0;
        u0 = n_up; d0 = n_dn; e0 = n_err;
        @(negedge clk); a = 1'b1;
        repeat (FILT - 2) @(negedge clk);
        a = 1'b0;
        repeat (GAP) @(negedge clk);
        chk(n_up == u0 && n_dn == d0 && n_err == e0, "R6 short glitch ignored",
            n_up + n_dn + n_err - u0 - d0 - e0, 0);
    endtask

    task automatic t_lockout();
        int u0;
        res = 2'b10;
        pw = 8'd40;
        u0 = n_up;
        @(negedge clk); a = 1'b1;
        repeat (15) @(negedge clk);
        b = 1'b1;
        repeat (60) @(negedge clk);
        chk(n_up - u0 == 1, "R7 change during pulse not counted", n_up - u0, 1);
        pw = 8'd5;
        step(0, 1);
        chk(n_up - u0 == 2, "R7 next change counts after lockout", n_up - u0, 2);
        step(0, 0);
    endtask

    task automatic t_illegal();
        int u0, d0, e0;
        res = 2'b10;
        u0 = n_up; d0 = n_dn; e0 = n_err;
        step(1, 1);
        chk(n_err - e0 == 1, "R8 err one cycle", n_err - e0, 1);
        chk(n_up == u0 && n_dn == d0, "R8 no count", n_up + n_dn - u0 - d0, 0);
        step(0, 1);
        chk(n_up - u0 == 1, "R8 reference taken after bad step", n_up - u0, 1);
        step(0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_mode(2'b00, 1, "R1");
        t_mode(2'b01, 2, "R2");
        t_mode(2'b10, 4, "R3");
        t_width(7, 7);
        t_width(0, 1);
        t_glitch();
        t_lockout();
        t_illegal();
        chk(n_split_bad == 0, "R10 cnt_n idle in split style", n_split_bad, 0);
        chk(n_cidle_bad == 0, "R9 up_n/dn_n idle in combined style", n_cidle_bad, 0);
        chk(n_dirmove == 0, "R9 direction held during pulse", n_dirmove, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule